// File: doc/BRIEF.md
# UART Receive Queue with Per-Byte Error Tags

This block is the receive side store of a serial port. Each byte handed over by the deserializer is kept together with its own error tags (parity, framing, break, and an overrun tag added later). The host sees the oldest byte on the read-data output. It also sees a line-status byte whose error bits describe only that oldest byte, plus one summary bit that stays high while any tagged byte is still queued.

Two interrupt requests are produced. The data-ready request follows the fill level against a programmable threshold in queued mode, or the presence of one byte in single-byte mode. The line-status request is latched when a bad byte arrives or an overrun happens. After software has cleared it by reading line status, it is latched again when that bad byte moves to the front of the queue. So one bad byte arriving behind good ones can produce two requests.

Top module: `rxq_errfifo`

## Requirements
- R1: After reset the queue is empty, the line-status value is 0x00, read data is 0x00, both interrupt enables are off and neither interrupt request is asserted.
- R2: Bytes leave in arrival order. `rd_data` shows the oldest byte, or 0x00 when empty. A `rd_data_stb` cycle removes it, and has no effect on an empty queue.
- R3: Capacity is DEPTH (64) bytes when `fifo_en` is 1 and one byte when `fifo_en` is 0. Any change of `fifo_en` empties the queue and clears the error summary in that cycle, ignoring that cycle's receive and read strobes.
- R4: A byte arriving while the queue is full and no byte leaves in the same cycle is discarded. It sets the overrun tag of the most recently stored byte. A byte that leaves in the same cycle frees room for it.
- R5: Line-status bit 0 is 1 while the queue is non-empty. Bits 1 (overrun), 2 (parity), 3 (framing) and 4 (break) show the tags of the oldest byte only. Bits 5 and 6 are 0.
- R6: Line-status bit 7 is 1 while at least one queued byte carries any tag, and 0 once the last such byte has left.
- R7: A pending line-status event is latched at the clock edge that stores a byte with any error flag or that records an overrun. A `rd_lsr_stb` cycle clears it unless a new event happens in that same cycle.
- R8: When a removal makes a tagged byte the oldest one, the line-status event is latched again at that edge.
- R9: The data-ready request is asserted, when enabled, while the fill is at least max(`trig_lvl`,1) with `fifo_en`=1, or while one byte is held with `fifo_en`=0.
- R10: A cycle with `ie_we` loads `ie_wdata` into the enables: bit 0 enables the data-ready request, bit 1 the line-status request. A disabled request stays low, but a latched line-status event raises the request as soon as it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | One-cycle strobe: a received byte is offered |
| rx_data | input | 8 | Received byte |
| rx_par_err | input | 1 | Parity error of the offered byte |
| rx_frm_err | input | 1 | Framing error of the offered byte |
| rx_brk | input | 1 | Offered byte is a break |
| fifo_en | input | 1 | 1 = queued mode, 0 = single-byte mode |
| trig_lvl | input | 7 | Data-ready fill threshold in queued mode |
| rd_data_stb | input | 1 | Remove the oldest byte |
| rd_lsr_stb | input | 1 | Line status is being read; clears the pending event |
| ie_we | input | 1 | Load the interrupt enables |
| ie_wdata | input | 2 | New enables: bit 0 data-ready, bit 1 line-status |
| rd_data | output | 8 | Oldest byte |
| lsr | output | 8 | Line-status value |
| irq_rx_data | output | 1 | Data-ready interrupt request |
| irq_line_stat | output | 1 | Line-status interrupt request |

## Verification
The hardest state to reach is an overrun on a full 64-byte queue, where the overrun tag lands on the newest byte. It only shows in bits 4:1 after 63 removals, and that same removal latches a second line-status event. Directed sequences fill the queue to the brim, overflow it and drain it one byte at a time. The same is done in single-byte mode, where the tagged byte is at once the newest and the oldest. Random phases then bias receive and removal rates in turn, so the fill drifts between empty and full while errors, status reads and mode switches land at random cycles. A bench model of the queue predicts every output after every edge.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int RXQ_DW = 8;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic              ovr;
    logic [RXQ_DW-1:0] data;
  } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic             mark_ovr,
  input  rxq_entry_t       push_entry,
  output rxq_entry_t       head,
  output logic             next_err,
  output logic             tail_err,
  output logic [CNT_W-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  rxq_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] rptr_q, rptr_d, wptr_q, wptr_d;
  logic [PTR_W-1:0] last_ptr, next_ptr;
  logic [CNT_W-1:0] cnt_d;
  rxq_entry_t       nxt_e, tail_e;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    next_ptr = ptr_inc(rptr_q);
    last_ptr = (wptr_q == '0) ? PTR_W'(DEPTH - 1) : wptr_q - PTR_W'(1);
    head     = mem[rptr_q];
    nxt_e    = mem[next_ptr];
    tail_e   = mem[last_ptr];
    next_err = nxt_e.ovr | nxt_e.par | nxt_e.frm | nxt_e.brk;
    tail_err = tail_e.ovr | tail_e.par | tail_e.frm | tail_e.brk;
  end

  always_comb begin
    rptr_d = rptr_q;
    wptr_d = wptr_q;
    cnt_d  = count;
    if (flush) begin
      rptr_d = '0;
      wptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (pop)  rptr_d = next_ptr;
      if (push) wptr_d = ptr_inc(wptr_q);
      cnt_d = count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      wptr_q <= '0;
      count  <= '0;
    end else begin
      rptr_q <= rptr_d;
      wptr_q <= wptr_d;
      count  <= cnt_d;
    end
  end

  // storage array: written only on enables, no reset
  always_ff @(posedge clk) begin
    if (push)     mem[wptr_q]       <= push_entry;
    if (mark_ovr) mem[last_ptr].ovr <= 1'b1;
  end

  AST_OVR_KEEPS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    mark_ovr |=> (count == $past(count)));  // R4
  AST_NO_PUSH_PAST_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (count < CNT_W'(DEPTH)));  // R3
endmodule

// File: rtl/rxq_errtrack.sv
module rxq_errtrack #(
  parameter  int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             push_err,
  input  logic             pop,
  input  logic             pop_err,
  input  logic             mark_ovr,
  input  logic             tail_err,
  input  logic             next_err,
  input  logic [CNT_W-1:0] count,
  input  logic             rd_lsr,
  output logic             err_any,
  output logic             lsi_pend
);
  logic [CNT_W-1:0] ecnt_q, ecnt_d;
  logic             pend_d, ls_event;
  logic             inc_arr, inc_ovr, dec_pop, head_turn;

  always_comb begin
    inc_arr   = push & push_err;
    inc_ovr   = mark_ovr & ~tail_err;
    dec_pop   = pop & pop_err;
    head_turn = pop & (count >= CNT_W'(2)) & next_err;
    ls_event  = inc_arr | mark_ovr | head_turn;

    if (flush) ecnt_d = '0;
    else       ecnt_d = ecnt_q + CNT_W'(inc_arr) + CNT_W'(inc_ovr) - CNT_W'(dec_pop);

    if (ls_event)    pend_d = 1'b1;
    else if (rd_lsr) pend_d = 1'b0;
    else             pend_d = lsi_pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt_q   <= '0;
      lsi_pend <= 1'b0;
    end else begin
      ecnt_q   <= ecnt_d;
      lsi_pend <= pend_d;
    end
  end

  assign err_any = (ecnt_q != '0);

  AST_ERRCNT_WITHIN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    ecnt_q <= count);  // R6
  AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    ls_event |=> lsi_pend);  // R7
  AST_HEAD_TURN_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    head_turn |=> lsi_pend);  // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && !ls_event) |=> !lsi_pend);  // R7
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq #(
  parameter  int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ie_we,
  input  logic [1:0]       ie_wdata,
  input  logic             fifo_en,
  input  logic [CNT_W-1:0] trig_lvl,
  input  logic [CNT_W-1:0] count,
  input  logic             lsi_pend,
  output logic             irq_rx_data,
  output logic             irq_line_stat
);
  logic [1:0]       ie_q, ie_d;
  logic [CNT_W-1:0] trig_eff;
  logic             rx_cond;

  always_comb begin
    ie_d     = ie_we ? ie_wdata : ie_q;
    trig_eff = (trig_lvl == '0) ? CNT_W'(1) : trig_lvl;
    rx_cond  = fifo_en ? (count >= trig_eff) : (count != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ie_q <= 2'b00;
    else        ie_q <= ie_d;
  end

  assign irq_rx_data   = ie_q[0] & rx_cond;
  assign irq_line_stat = ie_q[1] & lsi_pend;

  AST_RXIRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_data |-> (count != '0));  // R9
  AST_IE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ie_we |=> (ie_q == $past(ie_wdata)));  // R10
endmodule

// File: rtl/rxq_errfifo.sv
module rxq_errfifo
  import rxq_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [RXQ_DW-1:0] rx_data,
  input  logic              rx_par_err,
  input  logic              rx_frm_err,
  input  logic              rx_brk,
  input  logic              fifo_en,
  input  logic [CNT_W-1:0]  trig_lvl,
  input  logic              rd_data_stb,
  input  logic              rd_lsr_stb,
  input  logic              ie_we,
  input  logic [1:0]        ie_wdata,
  output logic [RXQ_DW-1:0] rd_data,
  output logic [7:0]        lsr,
  output logic              irq_rx_data,
  output logic              irq_line_stat
);
  logic [1:0]       rsync_q;
  logic             srst_n;
  logic             fen_q, flush;
  logic [CNT_W-1:0] cap, count;
  logic             has_data, full, pop, push, mark_ovr, push_err;
  logic             pop_err, next_err, tail_err, err_any, lsi_pend;
  rxq_entry_t       head, head_v, in_e;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) fen_q <= 1'b0;
    else         fen_q <= fifo_en;
  end

  always_comb begin
    flush    = fifo_en ^ fen_q;
    cap      = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
    has_data = (count != '0);
    full     = (count >= cap);
    pop      = rd_data_stb & has_data & ~flush;
    push     = rx_valid & ~flush & (~full | pop);
    mark_ovr = rx_valid & ~flush & full & ~pop;
    push_err = rx_par_err | rx_frm_err | rx_brk;
    in_e     = '{brk: rx_brk, frm: rx_frm_err, par: rx_par_err, ovr: 1'b0, data: rx_data};
    head_v   = has_data ? head : '0;
    pop_err  = head.ovr | head.par | head.frm | head.brk;
  end

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(srst_n), .flush(flush), .push(push), .pop(pop),
    .mark_ovr(mark_ovr), .push_entry(in_e), .head(head),
    .next_err(next_err), .tail_err(tail_err), .count(count)
  );

  rxq_errtrack #(.DEPTH(DEPTH)) u_err (
    .clk(clk), .rst_n(srst_n), .flush(flush), .push(push), .push_err(push_err),
    .pop(pop), .pop_err(pop_err), .mark_ovr(mark_ovr), .tail_err(tail_err),
    .next_err(next_err), .count(count), .rd_lsr(rd_lsr_stb),
    .err_any(err_any), .lsi_pend(lsi_pend)
  );

  rxq_irq #(.DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst_n(srst_n), .ie_we(ie_we), .ie_wdata(ie_wdata),
    .fifo_en(fifo_en), .trig_lvl(trig_lvl), .count(count), .lsi_pend(lsi_pend),
    .irq_rx_data(irq_rx_data), .irq_line_stat(irq_line_stat)
  );

  assign rd_data = head_v.data;
  assign lsr     = {err_any, 2'b00, head_v.brk, head_v.frm, head_v.par, head_v.ovr, has_data};

  AST_SUMMARY_COVERS_HEAD: assert property (@(posedge clk) disable iff (!srst_n)
    (lsr[4:1] != 4'b0) |-> lsr[7]);  // R6
  AST_FILL_WITHIN_CAP: assert property (@(posedge clk) disable iff (!srst_n)
    !flush |-> (count <= cap));  // R3
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!srst_n)
    flush |=> (lsr[0] == 1'b0 && lsr[7] == 1'b0));  // R3
endmodule

// File: tb/tb_rxq_errfifo.sv
module tb_rxq_errfifo;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       v_rxv, v_pe, v_fe, v_bi, v_fen, v_rd, v_rdlsr, v_iewe;
  logic [7:0] v_data;
  logic [6:0] v_trig;
  logic [1:0] v_iewd;
  logic [7:0] rd_data, lsr;
  logic       irq_rx_data, irq_line_stat;

  int tests = 0, fails = 0;
  bit done = 0;

  // bench model of the queue
  logic [7:0] md [DEPTH];
  logic [3:0] mf [DEPTH];   // {brk,frm,par,ovr}
  int         m_cnt;
  bit         m_fenq, m_pend;
  logic [1:0] m_ie;

  always #2.5 clk = ~clk;

  rxq_errfifo #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(v_rxv), .rx_data(v_data),
    .rx_par_err(v_pe), .rx_frm_err(v_fe), .rx_brk(v_bi), .fifo_en(v_fen),
    .trig_lvl(v_trig), .rd_data_stb(v_rd), .rd_lsr_stb(v_rdlsr),
    .ie_we(v_iewe), .ie_wdata(v_iewd), .rd_data(rd_data), .lsr(lsr),
    .irq_rx_data(irq_rx_data), .irq_line_stat(irq_line_stat)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit flush, pop, full, acc, ovr, ev;
    int cap;
    ev = 0;
    flush = (v_fen != m_fenq);
    if (v_iewe) m_ie = v_iewd;
    if (flush) begin
      m_cnt  = 0;
      m_fenq = v_fen;
    end else begin
      cap  = v_fen ? DEPTH : 1;
      pop  = v_rd && (m_cnt > 0);
      full = (m_cnt >= cap);
      acc  = v_rxv && (!full || pop);
      ovr  = v_rxv && full && !pop;
      if (pop) begin
        if (m_cnt >= 2 && mf[1] != 0) ev = 1;
        for (int i = 0; i < DEPTH - 1; i++) begin
          md[i] = md[i+1];
          mf[i] = mf[i+1];
        end
        m_cnt--;
      end
      if (acc) begin
        md[m_cnt] = v_data;
        mf[m_cnt] = {v_bi, v_fe, v_pe, 1'b0};
        m_cnt++;
        if (v_pe || v_fe || v_bi) ev = 1;
      end
      if (ovr) begin
        mf[m_cnt-1][0] = 1'b1;
        ev = 1;
      end
    end
    if (ev)          m_pend = 1;
    else if (v_rdlsr) m_pend = 0;
  endtask

  function automatic logic [7:0] exp_lsr();
    bit sum = 0;
    for (int i = 0; i < DEPTH; i++) if (i < m_cnt && mf[i] != 0) sum = 1;
    if (m_cnt == 0) return {sum, 7'b0};
    return {sum, 2'b00, mf[0], 1'b1};
  endfunction

  function automatic bit exp_irq_rx();
    int t = (v_trig == 0) ? 1 : int'(v_trig);
    if (!m_ie[0]) return 0;
    return v_fen ? (m_cnt >= t) : (m_cnt != 0);
  endfunction

  task automatic compare();
    logic [7:0] el = exp_lsr();
    logic [7:0] ed = (m_cnt > 0) ? md[0] : 8'h00;
    chk(rd_data == ed, "R2 rd_data", rd_data, ed);
    chk(lsr[6:0] == el[6:0], "R5 lsr[6:0]", lsr, el);
    chk(lsr[7] == el[7], "R6 lsr[7]", lsr[7], el[7]);
    chk(irq_rx_data == exp_irq_rx(), "R9 irq_rx_data", irq_rx_data, exp_irq_rx());
    chk(irq_line_stat == (m_ie[1] & m_pend), "R7 irq_line_stat", irq_line_stat, m_ie[1] & m_pend);
  endtask

  task automatic idle_in();
    v_rxv = 0; v_pe = 0; v_fe = 0; v_bi = 0; v_rd = 0; v_rdlsr = 0; v_iewe = 0;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    compare();
    idle_in();
  endtask

  task automatic push_b(input logic [7:0] d, input bit pe, input bit fe, input bit bi);
    v_rxv = 1; v_data = d; v_pe = pe; v_fe = fe; v_bi = bi;
    step();
  endtask

  task automatic pop_b();
    v_rd = 1;
    step();
  endtask

  task automatic rd_lsr();
    v_rdlsr = 1;
    step();
  endtask

  task automatic set_ie(input logic [1:0] v);
    v_iewe = 1; v_iewd = v;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    rst_n = 0; v_fen = 0; v_trig = 7'd1; v_iewd = 2'b00; v_data = 8'h00;
    idle_in();
    m_cnt = 0; m_fenq = 0; m_pend = 0; m_ie = 2'b00;
    for (int i = 0; i < DEPTH; i++) begin md[i] = 8'h00; mf[i] = 4'h0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) step();
    // R1: reset state
    chk(lsr == 8'h00, "R1 lsr", lsr, 8'h00);
    chk(rd_data == 8'h00, "R1 rd_data", rd_data, 8'h00);
    chk({irq_rx_data, irq_line_stat} == 2'b00, "R1 irqs", {irq_rx_data, irq_line_stat}, 2'b00);

    // queued mode: good byte then parity-bad byte
    v_fen = 1; step();
    push_b(8'h55, 0, 0, 0);
    push_b(8'hAA, 1, 0, 0);
    chk(lsr == 8'h81, "R6 clean head with bad byte queued", lsr, 8'h81);
    chk(irq_line_stat == 1'b0, "R10 disabled request low", irq_line_stat, 1'b0);
    set_ie(2'b10);
    chk(irq_line_stat == 1'b1, "R10 latched event shows on enable", irq_line_stat, 1'b1);
    rd_lsr();
    chk(irq_line_stat == 1'b0, "R7 lsr read clears", irq_line_stat, 1'b0);
    pop_b();
    chk(rd_data == 8'hAA, "R2 second byte at head", rd_data, 8'hAA);
    chk(lsr == 8'h85, "R5 parity at bit 2", lsr, 8'h85);
    chk(irq_line_stat == 1'b1, "R8 re-raised at head", irq_line_stat, 1'b1);
    pop_b();
    chk(lsr == 8'h00, "R6 summary clears when drained", lsr, 8'h00);
    pop_b();
    chk(rd_data == 8'h00, "R2 pop on empty ignored", rd_data, 8'h00);
    rd_lsr();

    // fill to capacity and overflow
    for (int i = 0; i < DEPTH; i++) push_b(8'(i + 1), 0, 0, 0);
    push_b(8'hEE, 0, 0, 0);
    chk(lsr == 8'h81, "R4 overrun tag on newest, head clean", lsr, 8'h81);
    chk(irq_line_stat == 1'b1, "R7 overrun latches event", irq_line_stat, 1'b1);
    rd_lsr();
    for (int i = 0; i < DEPTH - 1; i++) begin
      chk(rd_data == 8'(i + 1), "R2 order", rd_data, 8'(i + 1));
      pop_b();
    end
    chk(rd_data == 8'(DEPTH), "R4 incoming byte discarded", rd_data, 8'(DEPTH));
    chk(lsr == 8'h83, "R4 overrun bit 1 on last byte", lsr, 8'h83);
    chk(irq_line_stat == 1'b1, "R8 overrun byte reaches head", irq_line_stat, 1'b1);
    pop_b(); rd_lsr();

    // single-byte mode
    v_fen = 0; step();
    push_b(8'h11, 0, 0, 0);
    push_b(8'h22, 0, 0, 0);
    chk(rd_data == 8'h11, "R3 depth one keeps first", rd_data, 8'h11);
    chk(lsr == 8'h83, "R4 overrun in single-byte mode", lsr, 8'h83);
    v_rd = 1; v_rxv = 1; v_data = 8'h33; step();
    chk(rd_data == 8'h33, "R4 pop frees room same cycle", rd_data, 8'h33);
    set_ie(2'b01);
    chk(irq_rx_data == 1'b1, "R9 single-byte data ready", irq_rx_data, 1'b1);
    pop_b();
    chk(lsr == 8'h00, "R3 single slot emptied", lsr, 8'h00);

    // threshold in queued mode
    v_fen = 1; v_trig = 7'd4; step();
    for (int i = 0; i < 3; i++) push_b(8'hC0 + 8'(i), 0, 0, 0);
    chk(irq_rx_data == 1'b0, "R9 below threshold", irq_rx_data, 1'b0);
    push_b(8'hC3, 0, 1, 1);
    chk(irq_rx_data == 1'b1, "R9 at threshold", irq_rx_data, 1'b1);
    v_fen = 0; v_rxv = 1; v_data = 8'h77; step();
    chk(lsr == 8'h00, "R3 mode change flushes", lsr, 8'h00);

    // random phases
    set_ie(2'b11);
    for (int ph = 0; ph < 12; ph++) begin
      int pw = (ph % 2 == 0) ? 80 : 25;
      int rw = (ph % 2 == 0) ? 10 : 70;
      for (int c = 0; c < 500; c++) begin
        v_rxv   = ($urandom % 100) < pw;
        v_data  = 8'($urandom);
        v_pe    = ($urandom % 10) == 0;
        v_fe    = ($urandom % 14) == 0;
        v_bi    = ($urandom % 20) == 0;
        v_rd    = ($urandom % 100) < rw;
        v_rdlsr = ($urandom % 6) == 0;
        v_iewe  = ($urandom % 60) == 0;
        v_iewd  = 2'($urandom);
        if (($urandom % 400) == 0) v_fen = ~v_fen;
        if (($urandom % 90) == 0)  v_trig = 7'($urandom % 70);
        step();
      end
      if (ph == 3) v_fen = 1;
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule